// File: doc/BRIEF.md
# Coprocessor Access Permission Register

This block holds a 32-bit control word that records, for each of fourteen coprocessor slots, a two-bit permission code, and it judges access requests against those codes. Software changes the word through a write port (enable plus data) and observes it on a read port. A requester presents a coprocessor number, a flag saying whether it runs privileged, and a strobe. One cycle later the block answers with either a grant pulse or an undefined-instruction exception pulse.

Only slots 10 and 11 are backed by storage. Every other slot, and the top four bits of the word, are tied to zero, which is the "denied" code. Permission codes are: 00 denied, 01 privileged only, 11 privileged and user, 10 reserved. The block treats the reserved code as a denial. Coprocessor numbers 14 and 15 have no slot and are always denied. Decoding the coprocessor instruction and taking the exception belong to neighbouring logic.

Top module: `cpac_ctrl`

## Requirements
- R1: After a synchronous active-high reset, rd_data is 0 and both grant and undef_exc are 0.
- R2: A write with wr_en high stores wr_data[21:20] as the slot 10 code and wr_data[23:22] as the slot 11 code. The stored value appears on rd_data in the following cycle.
- R3: Bits [31:24] and [19:0] of rd_data read 0 at all times, whatever data was written.
- R4: A request to a slot whose code is 00 yields undef_exc and no grant, in both privileged and user mode.
- R5: Code 01 grants a privileged request and raises undef_exc for a user request.
- R6: Code 11 grants requests in both privileged and user mode.
- R7: The reserved code 10 is judged as denied in both modes.
- R8: Requests to coprocessor 14 or 15, and requests to any slot without storage, always give undef_exc.
- R9: Each strobe produces exactly one one-cycle pulse on grant or on undef_exc, in the cycle after the strobe. With no strobe, both outputs stay 0.
- R10: A request made in the same cycle as a write is judged against the codes held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the permission word |
| wr_data | input | 32 | Data for the permission word |
| rd_data | output | 32 | Current permission word |
| req_valid | input | 1 | Access request strobe |
| req_cp | input | 4 | Requested coprocessor number |
| req_priv | input | 1 | 1 = privileged requester, 0 = user |
| grant | output | 1 | Access permitted (one-cycle pulse) |
| undef_exc | output | 1 | Access denied, raise undefined-instruction exception (one-cycle pulse) |

## Verification
A corrupted stored code shows up on rd_data in the cycle after the write that set it. It also shows up as a wrong grant or exception pulse on the next request to that slot, one cycle after the strobe. A fixed slot or reserved bit that accidentally took storage becomes visible on rd_data as soon as any write sets it. A wrong decoding of the reserved code, or of the numbers above 13, only appears when a request hits that code or number. For that reason the stimulus places every code in both live slots and probes every slot number in both modes.

// File: rtl/cpac_pkg.sv
package cpac_pkg;
  localparam int unsigned CPAC_DATA_W  = 32;
  localparam int unsigned CPAC_SLOTS   = 14;
  localparam int unsigned CPAC_FIELD_W = 2;
  localparam int unsigned CPAC_NUM_W   = 4;

  typedef enum logic [CPAC_FIELD_W-1:0] {
    PERM_DENY = 2'b00,
    PERM_PRIV = 2'b01,
    PERM_RSVD = 2'b10,
    PERM_ALL  = 2'b11
  } perm_e;

  function automatic logic perm_allows(input logic [CPAC_FIELD_W-1:0] code,
                                       input logic priv);
    case (code)
      PERM_ALL:  perm_allows = 1'b1;
      PERM_PRIV: perm_allows = priv;
      default:   perm_allows = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cpac_field_bank.sv
module cpac_field_bank #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SLOTS     = 14,
  parameter int unsigned FIELD_W   = 2,
  parameter logic [SLOTS-1:0] IMPL_MASK = 14'b00_1100_0000_0000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [SLOTS-1:0][FIELD_W-1:0] fields,
  output logic [DATA_W-1:0]             word
);
  import cpac_pkg::*;
  localparam int unsigned FIELD_BITS = SLOTS * FIELD_W;
  localparam int unsigned PAD_BITS   = DATA_W - FIELD_BITS;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (IMPL_MASK[s]) begin : g_impl
      logic [FIELD_W-1:0] code_q;
      always_ff @(posedge clk) begin
        if (rst)        code_q <= PERM_DENY;
        else if (wr_en) code_q <= wr_data[s*FIELD_W +: FIELD_W];
      end
      assign fields[s] = code_q;
    end else begin : g_fixed
      assign fields[s] = PERM_DENY;
    end
  end

  assign word = {{PAD_BITS{1'b0}}, fields};

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;
endmodule

// File: rtl/cpac_perm_check.sv
module cpac_perm_check #(
  parameter int unsigned SLOTS   = 14,
  parameter int unsigned FIELD_W = 2,
  parameter int unsigned NUM_W   = 4
) (
  input  logic [SLOTS-1:0][FIELD_W-1:0] fields,
  input  logic [NUM_W-1:0]              cp_num,
  input  logic                          priv,
  output logic                          permit
);
  import cpac_pkg::*;
  logic [FIELD_W-1:0] sel_code;

  always_comb begin
    sel_code = PERM_DENY;
    for (int s = 0; s < SLOTS; s++) begin
      if (cp_num == NUM_W'(s)) sel_code = fields[s];
    end
  end

  assign permit = perm_allows(sel_code, priv);
endmodule

// File: rtl/cpac_resp_reg.sv
module cpac_resp_reg (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic permit,
  output logic grant,
  output logic undef_exc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grant     <= 1'b0;
      undef_exc <= 1'b0;
    end else begin
      grant     <= req_valid & permit;
      undef_exc <= req_valid & ~permit;
    end
  end
endmodule

// File: rtl/cpac_ctrl.sv
module cpac_ctrl #(
  parameter int unsigned DATA_W    = cpac_pkg::CPAC_DATA_W,
  parameter int unsigned SLOTS     = cpac_pkg::CPAC_SLOTS,
  parameter int unsigned FIELD_W   = cpac_pkg::CPAC_FIELD_W,
  parameter int unsigned NUM_W     = cpac_pkg::CPAC_NUM_W,
  parameter logic [SLOTS-1:0] IMPL_MASK = 14'b00_1100_0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              req_valid,
  input  logic [NUM_W-1:0]  req_cp,
  input  logic              req_priv,
  output logic              grant,
  output logic              undef_exc
);
  logic [SLOTS-1:0][FIELD_W-1:0] fields;
  logic                          permit;

  cpac_field_bank #(
    .DATA_W(DATA_W), .SLOTS(SLOTS), .FIELD_W(FIELD_W), .IMPL_MASK(IMPL_MASK)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fields(fields), .word(rd_data)
  );

  cpac_perm_check #(
    .SLOTS(SLOTS), .FIELD_W(FIELD_W), .NUM_W(NUM_W)
  ) u_check (
    .fields(fields), .cp_num(req_cp), .priv(req_priv), .permit(permit)
  );

  cpac_resp_reg u_resp (
    .clk(clk), .rst(rst), .req_valid(req_valid), .permit(permit),
    .grant(grant), .undef_exc(undef_exc)
  );
endmodule

// File: rtl/cpac_ctrl_chk.sv
module cpac_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] rd_data,
  input logic        req_valid,
  input logic [3:0]  req_cp,
  input logic        req_priv,
  input logic        grant,
  input logic        undef_exc
);
  logic [1:0] cur_code;
  assign cur_code = 2'((rd_data >> {req_cp, 1'b0}) & 32'h3);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == 32'h0 && !grant && !undef_exc));

  // R3
  fixed_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data & 32'hFF0F_FFFF) == 32'h0);

  // R9
  resp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant, undef_exc}));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(req_valid)) |-> (!grant && !undef_exc));

  // R9
  strobe_answered_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid)) |-> (grant || undef_exc));

  // R8
  high_num_denied_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(req_cp) >= 4'd14) |-> !grant);

  // R5
  user_needs_all_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && !$past(req_priv) && $past(req_cp) < 4'd14
     && $past(cur_code) != 2'b11) |-> !grant);
endmodule

bind cpac_ctrl cpac_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .req_valid(req_valid),
  .req_cp(req_cp), .req_priv(req_priv), .grant(grant), .undef_exc(undef_exc)
);

// File: tb/cpac_ctrl_bench.sv
module cpac_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LIVE_MASK = 32'h00F0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        req_valid = 1'b0;
  logic [3:0]  req_cp = '0;
  logic        req_priv = 1'b0;
  logic        grant, undef_exc;

  int checks = 0;
  int failures = 0;
  logic [31:0] model = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpac_ctrl u_cpac_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .req_valid(req_valid), .req_cp(req_cp), .req_priv(req_priv),
    .grant(grant), .undef_exc(undef_exc)
  );

  function automatic bit exp_permit(logic [31:0] word, logic [3:0] cp, logic pv);
    logic [1:0] code;
    if (cp >= 4'd14) return 1'b0;
    code = 2'((word >> (2*cp)) & 32'h3);
    if (code == 2'b11) return 1'b1;
    if (code == 2'b01) return pv;
    return 1'b0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive after a negedge, sample at the next negedge
  task automatic step(bit we, logic [31:0] d, bit rv, logic [3:0] cp, bit pv, string tag);
    logic [31:0] prev;
    bit g_exp;
    prev = model;
    wr_en = we; wr_data = d; req_valid = rv; req_cp = cp; req_priv = pv;
    @(negedge clk);
    if (we) model = d & LIVE_MASK;
    g_exp = rv && exp_permit(prev, cp, pv);
    check({tag, " rd_data"}, rd_data, model);
    check({tag, " grant"}, {31'b0, grant}, {31'b0, g_exp});
    check({tag, " undef_exc"}, {31'b0, undef_exc}, {31'b0, rv && !g_exp});
    wr_en = 0; req_valid = 0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 5000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 32'h0);
    check("R1 reset grant", {31'b0, grant}, 32'h0);
    check("R1 reset undef_exc", {31'b0, undef_exc}, 32'h0);

    // R4 reset code 00 on live slots
    step(0, 0, 1, 4'd10, 1, "R4 cp10 priv");
    step(0, 0, 1, 4'd11, 0, "R4 cp11 user");
    // R2/R3 write all ones: only live bits remain
    step(1, 32'hFFFF_FFFF, 0, 0, 0, "R2 R3 write ones");
    check("R3 fixed bits", rd_data & 32'hFF0F_FFFF, 32'h0);
    // R6 code 11
    step(0, 0, 1, 4'd10, 0, "R6 cp10 user");
    step(0, 0, 1, 4'd11, 1, "R6 cp11 priv");
    // R8 fixed slots and high numbers
    step(0, 0, 1, 4'd0, 1, "R8 cp0");
    step(0, 0, 1, 4'd9, 1, "R8 cp9");
    step(0, 0, 1, 4'd12, 1, "R8 cp12");
    step(0, 0, 1, 4'd14, 1, "R8 cp14");
    step(0, 0, 1, 4'd15, 1, "R8 cp15");
    // R5 code 01 in cp10, R7 code 10 in cp11
    step(1, 32'h0090_0000, 0, 0, 0, "R2 write 01/10");
    step(0, 0, 1, 4'd10, 1, "R5 cp10 priv");
    step(0, 0, 1, 4'd10, 0, "R5 cp10 user");
    step(0, 0, 1, 4'd11, 1, "R7 cp11 priv");
    step(0, 0, 1, 4'd11, 0, "R7 cp11 user");
    // R10 request alongside write uses old codes
    step(1, 32'h00F0_0000, 1, 4'd11, 1, "R10 write with request");
    step(0, 0, 1, 4'd11, 1, "R10 after write");
    // R9 idle
    step(0, 0, 0, 4'd11, 1, "R9 idle");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      d = $urandom;
      step(bit'($urandom % 3 == 0), d, bit'($urandom & 1), 4'($urandom), bit'($urandom & 1),
           "R2 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule